// File: doc/BRIEF.md
# Receive Bit-Error-Rate Monitor

The block watches a serial bit stream, qualified by a per-bit enable, and checks it against a 2^15-1 pseudo-random sequence built from the polynomial x^15 + x^14 + 1. While it is hunting for the pattern, it fills its sequence register with the received bits. As a result, it locks to any phase of the sequence without outside help. Once locked, the register runs on its own, and every received bit that differs from the prediction counts as a bit error.

The block keeps two saturating counters: one for bits received in lock and one for errors found in lock. It keeps eight status bits. One is the live lock state. The other seven are latched flags that clear when read: bit error, each counter reaching its maximum, start of a pattern search, a long run of zeros, a long run of ones, and a change in lock state. An interrupt output combines three enable inputs and a global mask.

A host reads the status word and the two counters through a small address/strobe port. A strobed read of the status word clears the latched flags.

Top module: `rx_bert_monitor`

## Requirements
- R1: After synchronous reset, the lock output is 0. Both counters read 0. The status word reads 0x10, meaning only the search flag is set. The interrupt output is 0.
- R2: While searching, a received bit counts as a match when it equals the XOR of the bits received 14 and 15 enabled bits earlier, where bits before reset count as 0. A mismatch restarts the run. On the clock edge that takes in the 32nd consecutive match, the lock output rises.
- R3: In lock, the sequence register runs free and predicts each bit. Counting restarts in 64-bit blocks from the moment of lock. The 6th mismatch inside one block drops lock, and searching starts again. Lock changes only on enabled bits.
- R4: While locked, each enabled bit adds one to the bit counter (address 1), and each mismatch adds one to the error counter (address 2). While not locked, neither counter moves.
- R5: Both counters saturate at all ones. Reaching the maximum sets status bit 2 for the bit counter and status bit 1 for the error counter. After such a flag is read, it is not set again until the counter is cleared and reaches its maximum once more.
- R6: The clear input zeroes both counters on the next edge. The clear wins over a count in the same cycle.
- R7: The status word at address 0 has this layout: bit 0 live lock, bit 3 bit-error flag (set by any mismatch in lock). A read strobe at address 0 clears the latched flags on that edge. A flag whose setting event falls in the same cycle stays set.
- R8: Status bit 4 (search flag) is set by reset and by every loss of lock. It stays set after lock returns, until it is read.
- R9: Status bit 5 is set after 31 consecutive received zeros, and bit 6 after 31 consecutive ones. A read does not clear either flag while its run is still unbroken. Once a bit of the other value has arrived, a read clears it.
- R10: Status bit 7 is set on every rise or fall of lock. The interrupt is high when the global mask input is 1 and one of these holds: the overflow enable is 1 with bit 1 or bit 2 set; the error enable is 1 with bit 3 set; the lock enable is 1 with bit 7 set.
- R11: The interrupt falls after a status read that clears the flag causing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Received data bit |
| bit_en | input | 1 | Qualifies bit_in for this cycle |
| cnt_clear | input | 1 | Zeroes both counters |
| ie_ovf | input | 1 | Interrupt enable for counter overflows |
| ie_err | input | 1 | Interrupt enable for bit errors |
| ie_sync | input | 1 | Interrupt enable for lock changes |
| int_mask | input | 1 | Global interrupt gate |
| rd_strobe | input | 1 | Read strobe; at address 0 it clears latched flags |
| rd_addr | input | 2 | 0 status, 1 bit counter, 2 error counter |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| sync_o | output | 1 | Live lock state |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are saturation of the counters and the "no re-arm after read" behaviour of the overflow flags. At full width these would take billions of bits. The bench therefore builds the block with a 12-bit bit counter and a 4-bit error counter. It then feeds long stretches of clean sequence, and sequence with errors placed every 16 bits, which stays under the loss threshold. This brings both counters to saturation, and the bench reads the flags, clears them and saturates the counters again. Loss and relock are reached by injecting errors densely enough to break a block, then resuming clean data. A reference model in the bench predicts the lock state bit by bit.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int PRBS_LEN = 15;

    typedef enum logic [1:0] {
        ADDR_STAT = 2'd0,
        ADDR_BITS = 2'd1,
        ADDR_ERRS = 2'd2
    } addr_e;

    // Latched flags, most significant first; {flags, live_sync} is the status word.
    typedef struct packed {
        logic chg;
        logic ra1;
        logic ra0;
        logic los;
        logic bed;
        logic bovf;
        logic eovf;
    } flags_t;

    function automatic logic prbs_pred(input logic [PRBS_LEN-1:0] hist);
        return hist[14] ^ hist[13];
    endfunction

endpackage

// File: rtl/rxb_sync.sv
module rxb_sync
    import rxb_pkg::*;
#(
    parameter int LOCK_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_en,
    output logic sync,
    output logic cnt_ev,
    output logic err_ev,
    output logic lost,
    output logic gained
);
    localparam int MW = $clog2(LOCK_RUN);
    localparam int WW = $clog2(WIN_LEN);
    localparam int EW = $clog2(LOSS_ERRS);

    logic [PRBS_LEN-1:0] shreg;
    logic [MW-1:0]       match_cnt;
    logic [WW-1:0]       win_cnt;
    logic [EW-1:0]       win_errs;
    logic                pred, mism;

    always_comb begin
        pred   = prbs_pred(shreg);
        mism   = bit_in ^ pred;
        cnt_ev = bit_en & sync;
        err_ev = cnt_ev & mism;
        lost   = err_ev & (win_errs == EW'(LOSS_ERRS - 1));
        gained = bit_en & ~sync & ~mism & (match_cnt == MW'(LOCK_RUN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            sync      <= 1'b0;
            match_cnt <= '0;
            win_cnt   <= '0;
            win_errs  <= '0;
        end else if (bit_en) begin
            shreg <= {shreg[PRBS_LEN-2:0], sync ? pred : bit_in};
            if (!sync) begin
                if (mism) begin
                    match_cnt <= '0;
                end else if (gained) begin
                    match_cnt <= '0;
                    sync      <= 1'b1;
                    win_cnt   <= '0;
                    win_errs  <= '0;
                end else begin
                    match_cnt <= match_cnt + 1'b1;
                end
            end else if (lost) begin
                sync     <= 1'b0;
                win_cnt  <= '0;
                win_errs <= '0;
            end else if (win_cnt == WW'(WIN_LEN - 1)) begin
                win_cnt  <= '0;
                win_errs <= '0;
            end else begin
                win_cnt  <= win_cnt + 1'b1;
                win_errs <= win_errs + EW'(mism);
            end
        end
    end

endmodule

// File: rtl/rxb_sat_cnt.sv
module rxb_sat_cnt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         hit_max
);
    localparam logic [W-1:0] CMAX = '1;

    assign hit_max = inc & ~clr & (cnt == (CMAX - W'(1)));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && cnt != CMAX)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/rxb_flags.sv
module rxb_flags
    import rxb_pkg::*;
#(
    parameter int RUN_LEN = 31
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_in,
    input  logic   bit_en,
    input  logic   err_ev,
    input  logic   lost,
    input  logic   gained,
    input  logic   eovf_hit,
    input  logic   bovf_hit,
    input  logic   rd_clr,
    input  logic   ie_ovf,
    input  logic   ie_err,
    input  logic   ie_sync,
    input  logic   int_mask,
    output flags_t flags,
    output logic   irq
);
    localparam int RW = $clog2(RUN_LEN + 1);

    logic [RW-1:0] run_len;
    logic          last_bit;
    logic          hold0, hold1;

    assign hold0 = (run_len == RW'(RUN_LEN)) & ~last_bit;
    assign hold1 = (run_len == RW'(RUN_LEN)) &  last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len  <= '0;
            last_bit <= 1'b0;
        end else if (bit_en) begin
            last_bit <= bit_in;
            if (bit_in == last_bit && run_len != '0)
                run_len <= (run_len == RW'(RUN_LEN)) ? run_len : run_len + 1'b1;
            else
                run_len <= RW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags     <= '0;
            flags.los <= 1'b1;
        end else begin
            flags.chg  <= lost | gained | (flags.chg  & ~rd_clr);
            flags.ra1  <= hold1         | (flags.ra1  & ~rd_clr);
            flags.ra0  <= hold0         | (flags.ra0  & ~rd_clr);
            flags.los  <= lost          | (flags.los  & ~rd_clr);
            flags.bed  <= err_ev        | (flags.bed  & ~rd_clr);
            flags.bovf <= bovf_hit      | (flags.bovf & ~rd_clr);
            flags.eovf <= eovf_hit      | (flags.eovf & ~rd_clr);
        end
    end

    assign irq = int_mask & ((ie_ovf  & (flags.eovf | flags.bovf)) |
                             (ie_err  & flags.bed) |
                             (ie_sync & flags.chg));

endmodule

// File: rtl/rx_bert_monitor.sv
module rx_bert_monitor
    import rxb_pkg::*;
#(
    parameter int BIT_W     = 32,
    parameter int ERR_W     = 24,
    parameter int LOCK_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 6,
    parameter int RUN_LEN   = 31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_in,
    input  logic        bit_en,
    input  logic        cnt_clear,
    input  logic        ie_ovf,
    input  logic        ie_err,
    input  logic        ie_sync,
    input  logic        int_mask,
    input  logic        rd_strobe,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        sync_o,
    output logic        irq
);
    logic             cnt_ev, err_ev, lost, gained;
    logic             eovf_hit, bovf_hit, rd_clr;
    logic [BIT_W-1:0] bit_cnt;
    logic [ERR_W-1:0] err_cnt;
    flags_t           flags;
    logic [7:0]       status_w;

    rxb_sync #(.LOCK_RUN(LOCK_RUN), .WIN_LEN(WIN_LEN), .LOSS_ERRS(LOSS_ERRS)) u_sync (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_en(bit_en),
        .sync(sync_o), .cnt_ev(cnt_ev), .err_ev(err_ev), .lost(lost), .gained(gained)
    );

    rxb_sat_cnt #(.W(BIT_W)) u_bits (
        .clk(clk), .rst(rst), .clr(cnt_clear), .inc(cnt_ev),
        .cnt(bit_cnt), .hit_max(bovf_hit)
    );

    rxb_sat_cnt #(.W(ERR_W)) u_errs (
        .clk(clk), .rst(rst), .clr(cnt_clear), .inc(err_ev),
        .cnt(err_cnt), .hit_max(eovf_hit)
    );

    assign rd_clr = rd_strobe & (addr_e'(rd_addr) == ADDR_STAT);

    rxb_flags #(.RUN_LEN(RUN_LEN)) u_flags (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_en(bit_en),
        .err_ev(err_ev), .lost(lost), .gained(gained),
        .eovf_hit(eovf_hit), .bovf_hit(bovf_hit), .rd_clr(rd_clr),
        .ie_ovf(ie_ovf), .ie_err(ie_err), .ie_sync(ie_sync), .int_mask(int_mask),
        .flags(flags), .irq(irq)
    );

    assign status_w = {flags, sync_o};

    always_comb begin
        case (addr_e'(rd_addr))
            ADDR_BITS: rd_data = 32'(bit_cnt);
            ADDR_ERRS: rd_data = 32'(err_cnt);
            default:   rd_data = 32'(status_w);
        endcase
    end

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
    parameter int BIT_W = 32,
    parameter int ERR_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_en,
    input logic             cnt_clear,
    input logic             int_mask,
    input logic             sync_o,
    input logic             irq,
    input logic [7:0]       status_w,
    input logic [BIT_W-1:0] bit_cnt,
    input logic [ERR_W-1:0] err_cnt
);
    localparam logic [BIT_W-1:0] BMAX = '1;

    a_r3_sync_on_bits: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(sync_o));

    a_r4_err_idle_unlocked: assert property (@(posedge clk) disable iff (rst)
        (!sync_o && !cnt_clear) |=> $stable(err_cnt));

    a_r4_bits_idle_unlocked: assert property (@(posedge clk) disable iff (rst)
        (!sync_o && !cnt_clear) |=> $stable(bit_cnt));

    a_r5_bits_saturate: assert property (@(posedge clk) disable iff (rst)
        (bit_cnt == BMAX && !cnt_clear) |=> bit_cnt == BMAX);

    a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
        cnt_clear |=> (bit_cnt == '0 && err_cnt == '0));

    a_r8_loss_sets_search: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_o) |-> status_w[4]);

    a_r10_mask_gates_irq: assert property (@(posedge clk) disable iff (rst)
        !int_mask |-> !irq);

endmodule

bind rx_bert_monitor rxb_checker #(.BIT_W(BIT_W), .ERR_W(ERR_W)) u_chk (
    .clk(clk), .rst(rst), .bit_en(bit_en), .cnt_clear(cnt_clear),
    .int_mask(int_mask), .sync_o(sync_o), .irq(irq), .status_w(status_w),
    .bit_cnt(bit_cnt), .err_cnt(err_cnt)
);

// File: tb/rx_bert_monitor_tb.sv
`timescale 1ns/1ps
module rx_bert_monitor_tb;
    localparam int BW = 12;
    localparam int EW = 4;
    localparam int BMAX = (1 << BW) - 1;
    localparam int EMAX = (1 << EW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0, bit_en = 1'b0, cnt_clear = 1'b0;
    logic ie_ovf = 1'b0, ie_err = 1'b0, ie_sync = 1'b0, int_mask = 1'b0;
    logic rd_strobe = 1'b0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic sync_o, irq;

    always #2.5 clk = ~clk;

    rx_bert_monitor #(.BIT_W(BW), .ERR_W(EW)) u_dut (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_en(bit_en), .cnt_clear(cnt_clear),
        .ie_ovf(ie_ovf), .ie_err(ie_err), .ie_sync(ie_sync), .int_mask(int_mask),
        .rd_strobe(rd_strobe), .rd_addr(rd_addr), .rd_data(rd_data),
        .sync_o(sync_o), .irq(irq)
    );

    int n_chk = 0, n_err = 0, trk_bad = 0;
    logic [14:0] gs = 15'h1;
    logic [14:0] m_sh;
    logic m_sync;
    int m_mc, m_wc, m_ec, m_bc, m_errc;
    logic [31:0] d;

    // Stimulus rows: bit count, error period (0 = clean), expected lock at row end
    localparam int unsigned VEC [5][3] = '{
        '{200, 0,  1},
        '{300, 50, 1},
        '{100, 8,  0},
        '{200, 0,  1},
        '{64,  20, 1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sh = '0; m_sync = 1'b0; m_mc = 0; m_wc = 0; m_ec = 0; m_bc = 0; m_errc = 0;
    endtask

    task automatic model_step(input logic b);
        logic p, mis;
        p = m_sh[14] ^ m_sh[13];
        mis = b ^ p;
        if (!m_sync) begin
            m_sh = {m_sh[13:0], b};
            if (mis) m_mc = 0;
            else if (m_mc == 31) begin m_mc = 0; m_sync = 1'b1; m_wc = 0; m_ec = 0; end
            else m_mc++;
        end else begin
            m_sh = {m_sh[13:0], p};
            if (m_bc != BMAX) m_bc++;
            if (mis && m_errc != EMAX) m_errc++;
            if (mis && m_ec == 5) begin m_sync = 1'b0; m_wc = 0; m_ec = 0; end
            else if (m_wc == 63) begin m_wc = 0; m_ec = 0; end
            else begin m_wc++; m_ec += int'(mis); end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        model_reset();
    endtask

    task automatic send_bit(input logic b);
        bit_in = b; bit_en = 1'b1;
        model_step(b);
        @(posedge clk); #1;
        bit_en = 1'b0;
        if (sync_o !== m_sync) trk_bad++;
    endtask

    task automatic send_prbs(input int n, input int period);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = gs[14] ^ gs[13];
            gs = {gs[13:0], b};
            if (period > 0 && (i % period) == period - 1) b = ~b;
            send_bit(b);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a; rd_strobe = 1'b1;
        #1 v = rd_data;
        @(posedge clk); #1;
        rd_strobe = 1'b0;
    endtask

    task automatic pulse_clear();
        cnt_clear = 1'b1;
        idle(1);
        cnt_clear = 1'b0;
        m_bc = 0; m_errc = 0;
    endtask

    initial begin
        #(5.0 * 190000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 sync", 32'(sync_o), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(2'd1, d); chk("R1 bitcnt", d, 0);
        rd(2'd2, d); chk("R1 errcnt", d, 0);
        rd(2'd0, d); chk("R1 status", d, 32'h10);

        // Table walk: R2 lock, R3 loss, R4 counting
        for (int r = 0; r < 5; r++) begin
            trk_bad = 0;
            send_prbs(int'(VEC[r][0]), int'(VEC[r][1]));
            chk($sformatf("R2/R3 row%0d per-bit lock track", r), trk_bad, 0);
            chk($sformatf("R3 row%0d lock", r), 32'(sync_o), VEC[r][2]);
            rd(2'd1, d); chk($sformatf("R4 row%0d bitcnt", r), d, 32'(m_bc));
            rd(2'd2, d); chk($sformatf("R4 row%0d errcnt", r), d, 32'(m_errc));
        end

        // R7/R8 latched flags, then clear on read
        rd(2'd0, d);
        chk("R8 search flag held after relock", 32'(d[4]), 1);
        chk("R7 error flag", 32'(d[3]), 1);
        chk("R10 change flag", 32'(d[7]), 1);
        rd(2'd0, d);
        chk("R7 cleared by read", d, 32'h1);

        // R6 clear wins over count
        cnt_clear = 1'b1;
        send_prbs(1, 0);
        cnt_clear = 1'b0;
        m_bc = 0; m_errc = 0;
        rd(2'd1, d); chk("R6 bitcnt clear priority", d, 0);
        rd(2'd2, d); chk("R6 errcnt clear", d, 0);
        send_prbs(10, 0);
        rd(2'd1, d); chk("R4 ten bits counted", d, 10);

        // R4 no counting while searching
        do_reset();
        send_prbs(10, 0);
        chk("R4 not locked yet", 32'(sync_o), 0);
        rd(2'd1, d); chk("R4 no count unlocked", d, 0);

        // R10/R11 interrupt
        int_mask = 1'b1; ie_sync = 1'b1;
        chk("R10 no irq without change", 32'(irq), 0);
        send_prbs(100, 0);
        chk("R10 irq on lock change", 32'(irq), 1);
        int_mask = 1'b0; #1;
        chk("R10 global mask", 32'(irq), 0);
        int_mask = 1'b1;
        rd(2'd0, d);
        chk("R11 irq drops after read", 32'(irq), 0);
        ie_sync = 1'b0;

        // R5 bit counter saturation and no re-arm
        pulse_clear();
        send_prbs(4200, 0);
        rd(2'd1, d); chk("R5 bitcnt saturated", d, BMAX);
        rd(2'd0, d); chk("R5 bit overflow flag", 32'(d[2]), 1);
        send_prbs(20, 0);
        rd(2'd0, d); chk("R5 no re-arm before clear", 32'(d[2]), 0);
        rd(2'd1, d); chk("R5 bitcnt stays max", d, BMAX);
        pulse_clear();
        send_prbs(4100, 0);
        rd(2'd0, d); chk("R5 re-armed after clear", 32'(d[2]), 1);

        // R5 error counter saturation, staying locked (4 errors per block)
        ie_ovf = 1'b1;
        pulse_clear();
        send_prbs(400, 16);
        chk("R3 still locked under light errors", 32'(sync_o), 1);
        rd(2'd2, d); chk("R5 errcnt saturated", d, EMAX);
        chk("R10 overflow irq", 32'(irq), 1);
        rd(2'd0, d); chk("R5 error overflow flag", 32'(d[1]), 1);
        chk("R11 irq cleared", 32'(irq), 0);
        ie_ovf = 1'b0;

        // R9 runs of ones and zeros
        do_reset();
        for (int i = 0; i < 30; i++) send_bit(1'b1);
        idle(2);
        rd(2'd0, d); chk("R9 30 ones no flag", 32'(d[6]), 0);
        send_bit(1'b1);
        idle(2);
        rd(2'd0, d); chk("R9 31 ones flag", 32'(d[6]), 1);
        rd(2'd0, d); chk("R9 held while run continues", 32'(d[6]), 1);
        send_bit(1'b0);
        idle(2);
        rd(2'd0, d); chk("R9 still latched", 32'(d[6]), 1);
        rd(2'd0, d); chk("R9 cleared after zero", 32'(d[6]), 0);
        for (int i = 0; i < 31; i++) send_bit(1'b0);
        idle(2);
        rd(2'd0, d); chk("R9 31 zeros flag", 32'(d[5]), 1);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule